// File: doc/BRIEF.md
# Oldest-First Bank Request Arbiter

One instance of this block sits in front of every interleaved memory bank of a vector machine. Several load/store units send element requests to the bank. A request carries the element index and a short sequence tag that gives the age of the instruction that issued it. The block keeps a small in-order queue for each unit. It accepts only the requests whose element index falls on its own bank, where bank = element index modulo the bank count. Each cycle it hands the bank's ports to the oldest waiting requests.

Up to NP queue entries are granted per cycle. Port 0 is filled first, then port 1, and so on. For each port, the candidate from a unit is the first entry of that unit's queue that has not yet been taken in this cycle. The oldest candidate wins. Age is compared modulo 2^TAG_W, so tags may wrap. When two candidates have equal age, the lower-numbered unit wins. A granted entry leaves its queue at the next clock edge. Entries that are not granted stay queued. When a unit's queue is full, that unit sees a stall and its request is not taken.

Top module: `vbank_age_arb`

## Requirements
- R1: While reset (rst_n low) is applied, every port_valid bit and every req_stall bit is 0.
- R2: A request whose req_elem modulo NBANKS differs from BANK_ID is discarded. It never reaches a port and takes no queue space.
- R3: At most NP grants are made per cycle. Each accepted request is granted exactly once, and a unit's requests leave in the order they arrived.
- R4: Tag a is older than tag b when (a - b) mod 2^TAG_W is at least 2^(TAG_W-1). Among the candidates, the oldest one gets the lowest-numbered free port.
- R5: The age comparison holds across tag wraparound. With TAG_W=4, tags 14 and 15 are both older than tag 1.
- R6: When candidates have equal tags, the lower-numbered unit wins.
- R7: Ports fill in order. port_valid[p] is 1 only if port_valid[p-1] is 1.
- R8: req_stall[u] is 1 exactly when unit u's queue holds DEPTH entries. A request presented while stalled is not accepted.
- R9: A request accepted at one clock edge can be granted in the following cycle. An entry that is not granted stays pending and is offered again in the next cycle.
- R10: One unit may receive several ports in the same cycle when its queued entries are older than the other units' heads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | NU | Request present, one bit per unit |
| req_tag | input | NU x TAG_W | Instruction sequence tag for each unit's request |
| req_elem | input | NU x ELEM_W | Element index for each unit's request |
| req_stall | output | NU | Unit queue full; the request is not taken |
| port_valid | output | NP | Bank port carries a granted request this cycle |
| port_src | output | NP x SRC_W | Unit that owns the granted request |
| port_tag | output | NP x TAG_W | Tag of the granted request |
| port_elem | output | NP x ELEM_W | Element index of the granted request |

## Verification
A queue pointer or count that goes wrong shows up at the ports in the next cycle. The symptoms are a repeated or skipped element index, or a stall at the wrong fill level. A faulty age comparison gives a younger tag a port ahead of an older one in the first cycle both are offered. The test cases that straddle the tag wrap point expose this quickly. A grant-count fault that pops too many or too few entries desynchronises the unit's element sequence, and the scoreboard flags it on the next port sample.

// File: rtl/vbank_age_arb_pkg.sv
package vbank_age_arb_pkg;

  // a is strictly older than b when the modular distance a-b falls in the upper half
  function automatic logic tag_older(input logic [31:0] a, input logic [31:0] b, input int w);
    logic [31:0] d;
    d = a - b;
    return d[w-1];
  endfunction

  // element i lives in bank (i mod nbanks)
  function automatic logic bank_hit(input logic [31:0] elem, input int nbanks, input int bank);
    return (int'(elem) % nbanks) == bank;
  endfunction

endpackage

// File: rtl/vbank_req_fifo.sv
module vbank_req_fifo #(
  parameter int DEPTH   = 4,
  parameter int ENTRY_W = 12,
  parameter int PEEK    = 2,
  parameter int POP_W   = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           push,
  input  logic [ENTRY_W-1:0]             push_entry,
  input  logic [POP_W-1:0]               pop_cnt,
  output logic                           full,
  output logic [PEEK-1:0]                peek_valid,
  output logic [PEEK-1:0][ENTRY_W-1:0]   peek_entry
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [DEPTH-1:0][ENTRY_W-1:0] mem;
  logic [PTR_W-1:0]              rd_ptr;
  logic [CNT_W-1:0]              cnt;
  logic [PTR_W-1:0]              wr_idx;

  assign full   = (cnt == CNT_W'(DEPTH));
  assign wr_idx = rd_ptr + cnt[PTR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      rd_ptr <= rd_ptr + PTR_W'(pop_cnt);
      cnt    <= cnt + CNT_W'(push) - CNT_W'(pop_cnt);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_idx] <= push_entry;
  end

  for (genvar k = 0; k < PEEK; k++) begin : g_peek
    assign peek_valid[k] = (cnt > CNT_W'(k));
    assign peek_entry[k] = mem[rd_ptr + PTR_W'(k)];
  end
endmodule

// File: rtl/vbank_age_pick.sv
module vbank_age_pick
  import vbank_age_arb_pkg::*;
#(
  parameter int NU    = 2,
  parameter int NP    = 2,
  parameter int TAG_W = 4,
  parameter int SRC_W = 1,
  parameter int POP_W = 2
) (
  input  logic [NU-1:0][NP-1:0]             cand_valid,
  input  logic [NU-1:0][NP-1:0][TAG_W-1:0]  cand_tag,
  output logic [NP-1:0]                     grant_valid,
  output logic [NP-1:0][SRC_W-1:0]          grant_src,
  output logic [NP-1:0][POP_W-1:0]          grant_slot,
  output logic [NU-1:0][POP_W-1:0]          pop_cnt
);
  logic             found;
  logic [SRC_W-1:0] best_u;
  logic [TAG_W-1:0] best_tag;
  logic [POP_W-1:0] best_slot;

  always_comb begin
    pop_cnt     = '0;
    grant_valid = '0;
    grant_src   = '0;
    grant_slot  = '0;
    found       = 1'b0;
    best_u      = '0;
    best_tag    = '0;
    best_slot   = '0;
    for (int p = 0; p < NP; p++) begin
      found     = 1'b0;
      best_u    = '0;
      best_tag  = '0;
      best_slot = '0;
      for (int u = 0; u < NU; u++) begin
        int slot;
        slot = int'(pop_cnt[u]);
        if (slot < NP) begin
          if (cand_valid[u][slot]) begin
            if (!found || tag_older(32'(cand_tag[u][slot]), 32'(best_tag), TAG_W)) begin
              found     = 1'b1;
              best_u    = SRC_W'(u);
              best_tag  = cand_tag[u][slot];
              best_slot = POP_W'(slot);
            end
          end
        end
      end
      if (found) begin
        grant_valid[p]  = 1'b1;
        grant_src[p]    = best_u;
        grant_slot[p]   = best_slot;
        pop_cnt[best_u] = pop_cnt[best_u] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/vbank_age_arb.sv
module vbank_age_arb
  import vbank_age_arb_pkg::*;
#(
  parameter int NU      = 2,
  parameter int NP      = 2,
  parameter int DEPTH   = 4,
  parameter int TAG_W   = 4,
  parameter int ELEM_W  = 8,
  parameter int NBANKS  = 8,
  parameter int BANK_ID = 3,
  localparam int SRC_W  = (NU > 1) ? $clog2(NU) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NU-1:0]                req_valid,
  input  logic [NU-1:0][TAG_W-1:0]     req_tag,
  input  logic [NU-1:0][ELEM_W-1:0]    req_elem,
  output logic [NU-1:0]                req_stall,
  output logic [NP-1:0]                port_valid,
  output logic [NP-1:0][SRC_W-1:0]     port_src,
  output logic [NP-1:0][TAG_W-1:0]     port_tag,
  output logic [NP-1:0][ELEM_W-1:0]    port_elem
);
  localparam int ENTRY_W = TAG_W + ELEM_W;
  localparam int POP_W   = $clog2(NP + 1);

  logic [NU-1:0]                        bank_match;
  logic [NU-1:0]                        push;
  logic [NU-1:0]                        lost_head;
  logic [NU-1:0][NP-1:0]                peek_valid;
  logic [NU-1:0][NP-1:0][ENTRY_W-1:0]   peek_entry;
  logic [NU-1:0][NP-1:0][TAG_W-1:0]     cand_tag;
  logic [NU-1:0][POP_W-1:0]             pop_cnt;
  logic [NP-1:0][POP_W-1:0]             grant_slot;

  for (genvar u = 0; u < NU; u++) begin : g_unit
    assign bank_match[u] = bank_hit(32'(req_elem[u]), NBANKS, BANK_ID);
    assign push[u]       = req_valid[u] && bank_match[u] && !req_stall[u];
    assign lost_head[u]  = peek_valid[u][0] && (pop_cnt[u] == '0);

    vbank_req_fifo #(
      .DEPTH  (DEPTH),
      .ENTRY_W(ENTRY_W),
      .PEEK   (NP),
      .POP_W  (POP_W)
    ) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push[u]),
      .push_entry({req_tag[u], req_elem[u]}),
      .pop_cnt   (pop_cnt[u]),
      .full      (req_stall[u]),
      .peek_valid(peek_valid[u]),
      .peek_entry(peek_entry[u])
    );

    for (genvar k = 0; k < NP; k++) begin : g_cand
      assign cand_tag[u][k] = peek_entry[u][k][ENTRY_W-1:ELEM_W];
    end
  end

  vbank_age_pick #(
    .NU   (NU),
    .NP   (NP),
    .TAG_W(TAG_W),
    .SRC_W(SRC_W),
    .POP_W(POP_W)
  ) u_pick (
    .cand_valid (peek_valid),
    .cand_tag   (cand_tag),
    .grant_valid(port_valid),
    .grant_src  (port_src),
    .grant_slot (grant_slot),
    .pop_cnt    (pop_cnt)
  );

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      port_tag[p]  = peek_entry[port_src[p]][grant_slot[p]][ENTRY_W-1:ELEM_W];
      port_elem[p] = peek_entry[port_src[p]][grant_slot[p]][ELEM_W-1:0];
    end
  end
endmodule

// File: rtl/vbank_age_arb_chk.sv
module vbank_age_arb_chk
  import vbank_age_arb_pkg::*;
#(
  parameter int NU      = 2,
  parameter int NP      = 2,
  parameter int TAG_W   = 4,
  parameter int ELEM_W  = 8,
  parameter int NBANKS  = 8,
  parameter int BANK_ID = 3,
  parameter int SRC_W   = 1,
  parameter int POP_W   = 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NU-1:0]             req_stall,
  input logic [NP-1:0]             port_valid,
  input logic [NP-1:0][SRC_W-1:0]  port_src,
  input logic [NP-1:0][TAG_W-1:0]  port_tag,
  input logic [NP-1:0][ELEM_W-1:0] port_elem,
  input logic [NU-1:0][POP_W-1:0]  pop_cnt
);
  for (genvar p = 0; p < NP; p++) begin : g_port
    p_bank_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
      port_valid[p] |-> bank_hit(32'(port_elem[p]), NBANKS, BANK_ID));
    if (p > 0) begin : g_pair
      p_fill_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        port_valid[p] |-> port_valid[p-1]);
      p_oldest_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (port_valid[p] && port_src[p] != port_src[p-1])
          |-> !tag_older(32'(port_tag[p]), 32'(port_tag[p-1]), TAG_W));
      p_tie_low_unit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (port_valid[p] && port_src[p] != port_src[p-1] && port_tag[p] == port_tag[p-1])
          |-> (port_src[p-1] < port_src[p]));
    end
  end

  for (genvar u = 0; u < NU; u++) begin : g_unit
    p_stall_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_stall[u] && pop_cnt[u] == '0) |=> req_stall[u]);
  end
endmodule

bind vbank_age_arb vbank_age_arb_chk #(
  .NU(NU), .NP(NP), .TAG_W(TAG_W), .ELEM_W(ELEM_W),
  .NBANKS(NBANKS), .BANK_ID(BANK_ID), .SRC_W(SRC_W), .POP_W(POP_W)
) u_chk (.*);

// File: tb/vbank_age_arb_tb.sv
module vbank_age_arb_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NU      = 3;
  localparam int NP      = 2;
  localparam int DEPTH   = 4;
  localparam int TAG_W   = 4;
  localparam int ELEM_W  = 8;
  localparam int NBANKS  = 8;
  localparam int BANK_ID = 3;
  localparam int SRC_W   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NU-1:0]              req_valid = '0;
  logic [NU-1:0][TAG_W-1:0]   req_tag   = '0;
  logic [NU-1:0][ELEM_W-1:0]  req_elem  = '0;
  logic [NU-1:0]              req_stall;
  logic [NP-1:0]              port_valid;
  logic [NP-1:0][SRC_W-1:0]   port_src;
  logic [NP-1:0][TAG_W-1:0]   port_tag;
  logic [NP-1:0][ELEM_W-1:0]  port_elem;

  always #(CLK_PERIOD/2) clk = ~clk;

  vbank_age_arb #(
    .NU(NU), .NP(NP), .DEPTH(DEPTH), .TAG_W(TAG_W),
    .ELEM_W(ELEM_W), .NBANKS(NBANKS), .BANK_ID(BANK_ID)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tag(req_tag),
    .req_elem(req_elem), .req_stall(req_stall), .port_valid(port_valid),
    .port_src(port_src), .port_tag(port_tag), .port_elem(port_elem)
  );

  typedef struct { int tag; int elem; } item_t;
  item_t sb[NU][$];

  int    n_chk = 0;
  int    n_bad = 0;
  int    cycles = 0;
  string cur_req = "R1";

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // signed view of the modular distance: negative means a came first
  function automatic bit age_first(input int a, input int b);
    int half;
    int d;
    half = 1 << (TAG_W - 1);
    d = (a - b) & ((1 << TAG_W) - 1);
    if (d >= half) d = d - (1 << TAG_W);
    return d < 0;
  endfunction

  // monitor: predicts grants from the scoreboard queues, compares, then advances the model
  always @(negedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
    if (!rst_n) begin
      for (int u = 0; u < NU; u++) sb[u].delete();
    end else begin
      int take[NU];
      bit was_full[NU];
      for (int u = 0; u < NU; u++) begin
        take[u] = 0;
        was_full[u] = (sb[u].size() == DEPTH);
        chk(req_stall[u] == was_full[u], "R8", $sformatf("stall unit %0d", u),
            int'(req_stall[u]), int'(was_full[u]));
      end
      for (int p = 0; p < NP; p++) begin
        int bu;
        int bt;
        int be;
        bu = -1; bt = 0; be = 0;
        for (int u = 0; u < NU; u++) begin
          if (take[u] < sb[u].size()) begin
            if (bu < 0 || age_first(sb[u][take[u]].tag, bt)) begin
              bu = u; bt = sb[u][take[u]].tag; be = sb[u][take[u]].elem;
            end
          end
        end
        if (p > 0 && port_valid[p])
          chk(port_valid[p-1] == 1'b1, "R7", $sformatf("port %0d filled before %0d", p, p-1), 0, 1);
        if (bu < 0) begin
          chk(port_valid[p] == 1'b0, cur_req, $sformatf("port %0d valid", p), int'(port_valid[p]), 0);
        end else begin
          take[bu]++;
          chk(port_valid[p] == 1'b1 && int'(port_src[p]) == bu &&
              int'(port_tag[p]) == bt && int'(port_elem[p]) == be, cur_req,
              $sformatf("port %0d v/src/tag/elem=%0d/%0d/%0d/%0d exp elem", p,
                        port_valid[p], port_src[p], port_tag[p], port_elem[p]),
              int'(port_elem[p]), be);
        end
      end
      for (int u = 0; u < NU; u++) begin
        for (int k = 0; k < take[u]; k++) void'(sb[u].pop_front());
        if (req_valid[u] && !was_full[u] && (int'(req_elem[u]) % NBANKS == BANK_ID)) begin
          item_t it;
          it.tag = int'(req_tag[u]);
          it.elem = int'(req_elem[u]);
          sb[u].push_back(it);
        end
      end
    end
  end

  // driver: one cycle of requests, applied just after a rising edge
  task automatic put(input bit [NU-1:0] v, input int t0, input int t1, input int t2,
                     input int e0, input int e1, input int e2);
    @(posedge clk); #1;
    req_valid = v;
    req_tag[0] = TAG_W'(t0);  req_tag[1] = TAG_W'(t1);  req_tag[2] = TAG_W'(t2);
    req_elem[0] = ELEM_W'(e0); req_elem[1] = ELEM_W'(e1); req_elem[2] = ELEM_W'(e2);
  endtask

  task automatic quiet(input int n);
    @(posedge clk); #1;
    req_valid = '0;
    repeat (n) @(posedge clk);
  endtask

  initial begin
    logic [15:0] lfsr;
    int base;
    int nx;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(port_valid == '0, "R1", "port_valid in reset", int'(port_valid), 0);
    chk(req_stall == '0, "R1", "req_stall in reset", int'(req_stall), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(port_valid == '0, "R1", "port_valid after reset", int'(port_valid), 0);

    // R4: oldest of three distinct tags first, the remaining one next cycle (R9)
    cur_req = "R4";
    put(3'b111, 5, 2, 7, 3, 11, 19);
    @(posedge clk); #1; req_valid = '0;
    @(negedge clk);
    chk(port_src[0] == 1 && port_src[1] == 0, "R4", "src pair", int'(port_src), 1);
    @(negedge clk);
    chk(port_valid == 2'b01 && port_src[0] == 2, "R9", "pending unit 2 served", int'(port_src[0]), 2);
    quiet(3);

    // R5: tags straddling the wrap point
    cur_req = "R5";
    put(3'b111, 1, 14, 15, 27, 35, 43);
    @(posedge clk); #1; req_valid = '0;
    @(negedge clk);
    chk(port_tag[0] == 14 && port_tag[1] == 15, "R5", "wrap order tag0", int'(port_tag[0]), 14);
    quiet(3);

    // R6: equal tags, lower unit first
    cur_req = "R6";
    put(3'b111, 6, 6, 6, 51, 59, 67);
    @(posedge clk); #1; req_valid = '0;
    @(negedge clk);
    chk(port_src[0] == 0 && port_src[1] == 1, "R6", "tie order src1", int'(port_src[1]), 1);
    quiet(3);

    // R2: only the element mapped to this bank is taken
    cur_req = "R2";
    put(3'b111, 1, 1, 1, 4, 10, 75);
    @(posedge clk); #1; req_valid = '0;
    @(negedge clk);
    chk(port_valid == 2'b01 && port_src[0] == 2, "R2", "valid ports for one hit", int'(port_valid), 1);
    @(negedge clk);
    chk(port_valid == '0, "R2", "no leak of misses", int'(port_valid), 0);
    quiet(2);

    // R10: a unit with two older entries takes both ports
    cur_req = "R10";
    put(3'b111, 3, 1, 1, 83, 91, 99);
    put(3'b001, 3, 0, 0, 107, 0, 0);
    @(posedge clk); #1; req_valid = '0;
    @(negedge clk);
    chk(port_valid == 2'b11 && port_src[0] == 0 && port_src[1] == 0, "R10", "both ports to unit 0",
        int'(port_src[1]), 0);
    quiet(3);

    // R8: unit 2 is always youngest and fills up
    cur_req = "R8";
    for (int i = 0; i < 8; i++) put(3'b111, 2, 2, 5, 3 + 8*i, 131 + 8*i, 195 + 8*i);
    @(negedge clk);
    chk(req_stall[2] == 1'b1, "R8", "unit 2 stalled", int'(req_stall[2]), 1);
    quiet(10);

    // R3: mixed traffic with slowly advancing tags
    cur_req = "R3";
    lfsr = 16'hACE1;
    base = 0;
    for (int i = 0; i < 400; i++) begin
      bit [NU-1:0] v;
      int t[NU];
      int e[NU];
      for (int u = 0; u < NU; u++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        v[u] = lfsr[0] | lfsr[1];
        t[u] = (base + int'(lfsr[3:2])) % (1 << TAG_W);
        nx = int'(lfsr[11:4]);
        e[u] = lfsr[12] ? ((nx & ~7) | BANK_ID) : nx;
      end
      if (i % 4 == 3) base = (base + 1) % (1 << TAG_W);
      put(v, t[0], t[1], t[2], e[0], e[1], e[2]);
    end
    quiet(12);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule